// File: doc/BRIEF.md
# Per-Thread Probabilistic Insertion Selector

This block picks the recency position at which a last-level-cache fill is inserted. The position is chosen on a per-thread basis. Every hardware thread owns a programmable 6-bit probability. When a new miss allocates its miss-handling entry, the cache raises a miss strobe together with the thread ID. In the same cycle the block compares a pseudo-random draw against that thread's probability. It returns either the long or the distant position, and the cache stores that position with the entry.

Software tunes the probabilities through a small register window. It also reads a saturating miss counter for each thread through the same window, so it can judge how well each probability is working. The search for the best probability runs entirely in software. The block only provides the table, the random source, the comparison and the counters.

Top module: `ins_sel`

## Requirements
- R1: After reset every probability reads 0, every miss counter reads 0, and the random generator holds 16'hACE1.
- R2: Register window: with `reg_addr_i[2]`=0, the entry at index `reg_addr_i[1:0]` is a probability. A write stores `reg_wdata_i[5:0]` and a read returns it zero-extended. With `reg_addr_i[2]`=1, index `reg_addr_i[1:0]` selects a miss counter, which reads zero-extended. `reg_rdata_o` is combinational.
- R3: While `miss_vld_i` is high, `pos_o` is 2'b10 (long) when `lfsr[5:0]` < probability[`miss_tid_i`] and 2'b11 (distant) otherwise. The decision uses the generator value held before that cycle's edge and is valid in the same cycle. While `miss_vld_i` is low, `pos_o` is 2'b11.
- R4: The generator is a 16-bit shift-left register. The new bit 0 is the XOR of bits 15, 13, 12 and 10. It advances exactly once on every clock edge with `miss_vld_i` high, holds otherwise, and never reaches zero.
- R5: Each miss strobe adds one to the counter of the thread named by `miss_tid_i`, and only to that counter.
- R6: A counter at its all-ones value stays there on further misses.
- R7: A write to a counter register clears that counter. When a miss to the same thread falls in the same cycle, the clear wins and the miss is not counted.
- R8: A probability write in the same cycle as a miss to that thread does not affect that miss. The new value applies from the next cycle.
- R9: Probability 0 always yields distant. Probability 63 yields long unless `lfsr[5:0]` is 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_vld_i | input | 1 | New miss allocating an entry |
| miss_tid_i | input | 2 | Hardware thread of the miss |
| pos_o | output | 2 | Insertion position: 10 long, 11 distant |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index: bit 2 selects counter, bits 1:0 thread |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |

## Verification
The bound assertions check on every cycle that:
- the generator is never zero and holds when no miss strobe is present;
- a strobed miss always yields one of the two legal position codes;
- probability 0 never yields long;
- counters increment by one, saturate, and clear on write.

Only the bench can show the actual comparison between the draw and each probability. It sweeps every probability value from 0 to 63 across all threads against an arithmetic model of the generator sequence. It also covers the same-cycle orderings of a write and a miss, and saturation in a narrow-counter configuration.

// File: rtl/ins_sel_pkg.sv
package ins_sel_pkg;
  typedef enum logic [1:0] {
    POS_LONG    = 2'b10,
    POS_DISTANT = 2'b11
  } ins_pos_e;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/ins_sel_lfsr.sv
module ins_sel_lfsr
  import ins_sel_pkg::*;
#(
  parameter int unsigned LFSR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [LFSR_W-1:0] state_o
);
  logic [LFSR_W-1:0] q;
  logic              fb;

  // taps for x^16+x^14+x^13+x^11+1
  assign fb = q[15] ^ q[13] ^ q[12] ^ q[10];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= LFSR_W'(LFSR_SEED);
    else if (adv_i) q <= {q[LFSR_W-2:0], fb};
  end

  assign state_o = q;
endmodule

// File: rtl/ins_sel_prob_tab.sv
module ins_sel_prob_tab #(
  parameter int unsigned N_THREADS = 4,
  parameter int unsigned PROB_W    = 6,
  localparam int unsigned TID_W    = $clog2(N_THREADS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [TID_W-1:0]  wr_idx_i,
  input  logic [PROB_W-1:0] wr_val_i,
  input  logic [TID_W-1:0]  miss_idx_i,
  output logic [PROB_W-1:0] miss_prob_o,
  input  logic [TID_W-1:0]  rd_idx_i,
  output logic [PROB_W-1:0] rd_prob_o
);
  logic [PROB_W-1:0] prob_q [N_THREADS];

  for (genvar t = 0; t < N_THREADS; t++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             prob_q[t] <= '0;
      else if (wr_i && wr_idx_i == TID_W'(t))  prob_q[t] <= wr_val_i;
    end
  end

  assign miss_prob_o = prob_q[miss_idx_i];
  assign rd_prob_o   = prob_q[rd_idx_i];
endmodule

// File: rtl/ins_sel_miss_cnt.sv
module ins_sel_miss_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               q <= '0;
    else if (clr_i)            q <= '0;
    else if (inc_i && ~&q)     q <= q + CNT_W'(1);
  end

  assign cnt_o = q;
endmodule

// File: rtl/ins_sel.sv
module ins_sel
  import ins_sel_pkg::*;
#(
  parameter int unsigned N_THREADS = 4,
  parameter int unsigned PROB_W    = 6,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LFSR_W    = 16,
  localparam int unsigned TID_W    = $clog2(N_THREADS),
  localparam int unsigned ADDR_W   = TID_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_vld_i,
  input  logic [TID_W-1:0]  miss_tid_i,
  output logic [1:0]        pos_o,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  logic [LFSR_W-1:0] lfsr_q;
  logic [PROB_W-1:0] prob_miss;
  logic [PROB_W-1:0] prob_rd;
  logic [CNT_W-1:0]  cnt_q [N_THREADS];
  logic              sel_cnt;
  logic [TID_W-1:0]  reg_idx;
  logic              unused_wdata;

  assign sel_cnt      = reg_addr_i[ADDR_W-1];
  assign reg_idx      = reg_addr_i[TID_W-1:0];
  assign unused_wdata = ^reg_wdata_i[DATA_W-1:PROB_W];

  ins_sel_lfsr #(.LFSR_W(LFSR_W)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (miss_vld_i),
    .state_o (lfsr_q)
  );

  ins_sel_prob_tab #(.N_THREADS(N_THREADS), .PROB_W(PROB_W)) u_tab (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i && !sel_cnt),
    .wr_idx_i    (reg_idx),
    .wr_val_i    (reg_wdata_i[PROB_W-1:0]),
    .miss_idx_i  (miss_tid_i),
    .miss_prob_o (prob_miss),
    .rd_idx_i    (reg_idx),
    .rd_prob_o   (prob_rd)
  );

  for (genvar t = 0; t < N_THREADS; t++) begin : g_cnt
    ins_sel_miss_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (miss_vld_i && miss_tid_i == TID_W'(t)),
      .clr_i  (reg_wr_i && sel_cnt && reg_idx == TID_W'(t)),
      .cnt_o  (cnt_q[t])
    );
  end

  always_comb begin
    pos_o = POS_DISTANT;
    if (miss_vld_i && (lfsr_q[PROB_W-1:0] < prob_miss)) pos_o = POS_LONG;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (sel_cnt) reg_rdata_o[CNT_W-1:0]  = cnt_q[reg_idx];
    else         reg_rdata_o[PROB_W-1:0] = prob_rd;
  end
endmodule

// File: rtl/ins_sel_chk.sv
module ins_sel_chk
  import ins_sel_pkg::*;
#(
  parameter int unsigned N_THREADS = 4,
  parameter int unsigned PROB_W    = 6,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned LFSR_W    = 16,
  localparam int unsigned TID_W    = $clog2(N_THREADS),
  localparam int unsigned ADDR_W   = TID_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              miss_vld_i,
  input logic [TID_W-1:0]  miss_tid_i,
  input logic [1:0]        pos_o,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [LFSR_W-1:0] lfsr_q,
  input logic [PROB_W-1:0] prob_miss,
  input logic [CNT_W-1:0]  cnt_q [N_THREADS]
);
  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);

  // R4
  lfsr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_vld_i |=> $stable(lfsr_q));

  // R3
  pos_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_vld_i |-> (pos_o == POS_LONG || pos_o == POS_DISTANT));

  // R9
  prob_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_vld_i && prob_miss == '0) |-> pos_o == POS_DISTANT);

  for (genvar t = 0; t < N_THREADS; t++) begin : g_cnt
    // R5
    cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (miss_vld_i && miss_tid_i == TID_W'(t) && !reg_wr_i && cnt_q[t] != '1)
        |=> cnt_q[t] == $past(cnt_q[t]) + CNT_W'(1));

    // R6
    cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q[t] == '1 && !reg_wr_i) |=> cnt_q[t] == '1);

    // R7
    cnt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_wr_i && reg_addr_i == {1'b1, TID_W'(t)}) |=> cnt_q[t] == '0);
  end
endmodule

bind ins_sel ins_sel_chk #(
  .N_THREADS (N_THREADS),
  .PROB_W    (PROB_W),
  .CNT_W     (CNT_W),
  .LFSR_W    (LFSR_W)
) u_chk (.*);

// File: tb/ins_sel_tb.sv
module ins_sel_tb;
  localparam int CNT_W = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_vld = 1'b0;
  logic [1:0]  miss_tid = '0;
  logic [1:0]  pos;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] lfsr_m = 16'hACE1;
  logic [5:0]  prob_m [4];
  int          cnt_m [4];

  always #2 clk = ~clk;

  ins_sel #(.CNT_W(CNT_W)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .miss_vld_i  (miss_vld),
    .miss_tid_i  (miss_tid),
    .pos_o       (pos),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata)
  );

  function automatic logic [15:0] step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    if (a[2]) cnt_m[a[1:0]] = 0;
    else      prob_m[a[1:0]] = d[5:0];
  endtask

  task automatic rd(input string req, input logic [2:0] a);
    logic [31:0] e;
    @(negedge clk);
    reg_addr = a; #1;
    e = a[2] ? 32'(cnt_m[a[1:0]]) : 32'(prob_m[a[1:0]]);
    chk(req, reg_rdata, e);
  endtask

  task automatic miss(input string req, input logic [1:0] t, input bit do_chk);
    logic [1:0] e;
    @(negedge clk);
    miss_vld = 1'b1; miss_tid = t; #1;
    e = (lfsr_m[5:0] < prob_m[t]) ? 2'b10 : 2'b11;
    if (do_chk) chk(req, 32'(pos), 32'(e));
    @(posedge clk); #1;
    miss_vld = 1'b0;
    lfsr_m = step(lfsr_m);
    if (cnt_m[t] < (1 << CNT_W) - 1) cnt_m[t]++;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin prob_m[i] = '0; cnt_m[i] = 0; end
    #9 rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) rd("R1", 3'(a));
    @(negedge clk); #1;
    chk("R3 idle", 32'(pos), 32'h3);

    // R9 probability 0 gives distant
    for (int i = 0; i < 8; i++) miss("R9", 2'(i), 1'b1);

    // R3/R2 sweep over all probabilities and threads
    for (int p = 0; p < 64; p++) begin
      wr({1'b0, 2'(p)}, 32'hFFFF_FFC0 | 32'(p));
      rd("R2 prob", {1'b0, 2'(p)});
      for (int k = 0; k < 5; k++) miss("R3", 2'(p), 1'b1);
    end

    // R9 probability 63 on all threads
    for (int t = 0; t < 4; t++) wr({1'b0, 2'(t)}, 32'd63);
    for (int i = 0; i < 40; i++) miss("R9", 2'(i), 1'b1);

    // R4 generator holds across idle cycles; sequence continues
    repeat (5) @(posedge clk);
    wr(3'b000, 32'd32);
    for (int i = 0; i < 16; i++) miss("R4", 2'b00, 1'b1);

    // R5 counters per thread
    for (int a = 4; a < 8; a++) rd("R5", 3'(a));

    // R7 clear
    wr(3'b110, 32'h0);
    rd("R7", 3'b110);
    rd("R5 others", 3'b111);

    // R7 clear wins over same-cycle miss
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'b101; miss_vld = 1'b1; miss_tid = 2'd1;
    @(posedge clk); #1;
    reg_wr = 1'b0; miss_vld = 1'b0;
    lfsr_m = step(lfsr_m); cnt_m[1] = 0;
    rd("R7 same cycle", 3'b101);

    // R8 probability write with same-cycle miss uses old value
    wr(3'b010, 32'd0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'b010; reg_wdata = 32'd63;
    miss_vld = 1'b1; miss_tid = 2'd2; #1;
    chk("R8 old prob", 32'(pos), 32'h3);
    @(posedge clk); #1;
    reg_wr = 1'b0; miss_vld = 1'b0;
    lfsr_m = step(lfsr_m); cnt_m[2]++; prob_m[2] = 6'd63;
    miss("R8 new prob", 2'd2, 1'b1);
    rd("R8 readback", 3'b010);

    // R6 saturation
    wr(3'b111, 32'h0);
    for (int i = 0; i < 260; i++) miss("R6", 2'd3, 1'b0);
    rd("R6", 3'b111);
    miss("R6 hold", 2'd3, 1'b1);
    rd("R6 hold", 3'b111);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule